// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Nibble-Carry Flags

This block is the arithmetic and logic datapath of an 8-bit accumulator machine. Each cycle it takes the accumulator W, a second operand (either a register value or an immediate literal), the current carry and an operation code. One clock later it presents the result byte, the high byte of a product, and new values for the zero (Z), carry (C) and nibble-carry (DC) flags. Each of these outputs comes with its own write enable. Surrounding logic uses those enables to update W, the addressed register, the product-high register and each flag bit. Nothing is written unless its enable is high.

Subtraction follows the "carry means no borrow" convention, and subtract-with-carry takes the inverted carry as its borrow. DC is the carry or the no-borrow out of bit 3. A direction input sends the result either to W or to the register operand. Literal forms and multiplies always target W.

The register file, the flag register and the instruction decoder are outside this block.

Top module: `alu8_dc`

## Requirements
- R1: ADD (op 1) gives W + operand, and ADDC (op 2) adds carry-in as well. Both set C to the carry out of bit 7, DC to the carry out of bit 3, and Z to (result == 0). All three flag enables are high.
- R2: SUB (op 3) gives operand − W, and SUBC (op 4) gives operand − W − (1 − carry-in). C is 1 when the full subtraction needs no borrow, and DC is 1 when the low-nibble subtraction needs no borrow. Z is set from the result, and all three flag enables are high.
- R3: CMP (op 5) updates C, DC and Z exactly as SUB would, but raises neither result write enable.
- R4: AND (6), OR (7) and XOR (8) combine W with the operand. NOT (9), INC (10) and DEC (11) act on the operand alone, with wraparound. Only Z is updated; the C and DC enables stay low.
- R5: RL (12) gives {operand[6:0], C} with the new C = operand[7]. RR (13) gives {C, operand[7:1]} with the new C = operand[0]. Only the C enable is high.
- R6: SWAP (14) exchanges the two nibbles of the operand and updates no flag.
- R7: MULU (15) multiplies W by the operand as unsigned values. The low byte goes to W and the high byte to the product-high output, whose enable is high. No flag changes.
- R8: MULS (16) multiplies with W treated as signed. A register operand is treated as signed and a literal operand as unsigned. Outputs are split as in R7.
- R9: When the literal-select input is 0, direction 0 routes the result to W and direction 1 routes it to the register. A literal operand or a multiply always routes to W. The two result enables are never high together.
- R10: MOV (op 0) with direction 0 copies the operand to W and sets Z, except that a literal source updates no flag. With direction 1 and a register source, it copies W to the register and updates no flag.
- R11: Op codes 17 to 31 raise no write enable of any kind.
- R12: All outputs are registered and appear on the clock edge after the inputs are sampled. An active-low asynchronous reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 5 | Operation code (see requirements) |
| dir_i | input | 1 | Destination: 0 = W, 1 = register |
| use_lit_i | input | 1 | 1 selects lit_i as operand, 0 selects reg_i |
| w_i | input | 8 | Accumulator value |
| reg_i | input | 8 | Register operand |
| lit_i | input | 8 | Literal operand |
| c_i | input | 1 | Current carry flag |
| res_o | output | 8 | Result byte |
| w_we_o | output | 1 | Write result to W |
| reg_we_o | output | 1 | Write result to register |
| mulh_o | output | 8 | Product high byte |
| mulh_we_o | output | 1 | Write product-high register |
| z_o | output | 1 | New zero flag |
| z_we_o | output | 1 | Zero flag enable |
| c_o | output | 1 | New carry flag |
| c_we_o | output | 1 | Carry flag enable |
| dc_o | output | 1 | New nibble-carry flag |
| dc_we_o | output | 1 | Nibble-carry flag enable |

## Verification
The block holds no state between operations, so any fault shows up in the very next cycle's outputs. The likely symptoms are a wrong byte, an inverted no-borrow sense, a wrong nibble carry, or a flag enable raised where it should stay low. An enable raised in error is the most serious of these, because it silently corrupts a flag or a register that the operation should have left alone. The bench therefore compares every enable on every operation, and compares flag values and data only where they are enabled.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OP_W = 5;
  typedef enum logic [OP_W-1:0] {
    OP_MOV  = 5'd0,  OP_ADD  = 5'd1,  OP_ADDC = 5'd2,  OP_SUB  = 5'd3,
    OP_SUBC = 5'd4,  OP_CMP  = 5'd5,  OP_AND  = 5'd6,  OP_OR   = 5'd7,
    OP_XOR  = 5'd8,  OP_NOT  = 5'd9,  OP_INC  = 5'd10, OP_DEC  = 5'd11,
    OP_RL   = 5'd12, OP_RR   = 5'd13, OP_SWAP = 5'd14, OP_MULU = 5'd15,
    OP_MULS = 5'd16
  } alu_op_e;
endpackage

// File: rtl/alu8_addsub.sv
// a + (inv ? ~b : b) + cin, with carry out of the low half and of the top bit
module alu8_addsub #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             inv_b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             hc_o,
  output logic             co_o
);
  localparam int HALF = WIDTH / 2;
  localparam int UP   = WIDTH - HALF;

  logic [WIDTH-1:0] bb;
  logic [HALF:0]    lo;
  logic [UP:0]      hi;

  always_comb begin
    bb = inv_b_i ? ~b_i : b_i;
    lo = {1'b0, a_i[HALF-1:0]} + {1'b0, bb[HALF-1:0]} + {{HALF{1'b0}}, cin_i};
    hi = {1'b0, a_i[WIDTH-1:HALF]} + {1'b0, bb[WIDTH-1:HALF]} + {{UP{1'b0}}, lo[HALF]};
  end

  assign sum_o = {hi[UP-1:0], lo[HALF-1:0]};
  assign hc_o  = lo[HALF];
  assign co_o  = hi[UP];
endmodule

// File: rtl/alu8_mul.sv
module alu8_mul #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  input  logic               sgn_a_i,
  input  logic               sgn_b_i,
  output logic [2*WIDTH-1:0] prod_o
);
  logic signed [WIDTH:0]     ax, bx;
  logic signed [2*WIDTH+1:0] p;

  always_comb begin
    ax = {sgn_a_i & a_i[WIDTH-1], a_i};
    bx = {sgn_b_i & b_i[WIDTH-1], b_i};
    p  = ax * bx;
  end

  assign prod_o = p[2*WIDTH-1:0];
endmodule

// File: rtl/alu8_unit.sv
// Logic, step, rotate and swap operations
module alu8_unit
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [OP_W-1:0]  op_i,
  input  logic [WIDTH-1:0] w_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] res_o,
  output logic             co_o
);
  localparam int HALF = WIDTH / 2;
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_comb begin
    res_o = '0;
    co_o  = c_i;
    unique case (op_i)
      OP_AND:  res_o = w_i & b_i;
      OP_OR:   res_o = w_i | b_i;
      OP_XOR:  res_o = w_i ^ b_i;
      OP_NOT:  res_o = ~b_i;
      OP_INC:  res_o = b_i + ONE;
      OP_DEC:  res_o = b_i - ONE;
      OP_RL: begin
        res_o = {b_i[WIDTH-2:0], c_i};
        co_o  = b_i[WIDTH-1];
      end
      OP_RR: begin
        res_o = {c_i, b_i[WIDTH-1:1]};
        co_o  = b_i[0];
      end
      OP_SWAP: res_o = {b_i[HALF-1:0], b_i[WIDTH-1:HALF]};
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu8_dc.sv
module alu8_dc
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [4:0]       op_i,
  input  logic             dir_i,
  input  logic             use_lit_i,
  input  logic [WIDTH-1:0] w_i,
  input  logic [WIDTH-1:0] reg_i,
  input  logic [WIDTH-1:0] lit_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] res_o,
  output logic             w_we_o,
  output logic             reg_we_o,
  output logic [WIDTH-1:0] mulh_o,
  output logic             mulh_we_o,
  output logic             z_o,
  output logic             z_we_o,
  output logic             c_o,
  output logic             c_we_o,
  output logic             dc_o,
  output logic             dc_we_o
);
  logic [WIDTH-1:0]   opnd;
  logic               is_sub, is_mul;
  logic [WIDTH-1:0]   as_a, as_b, as_sum, u_res;
  logic               as_cin, as_hc, as_co, u_co;
  logic [2*WIDTH-1:0] prod;

  logic [WIDTH-1:0] n_res, n_mh;
  logic n_wr, n_force_w, n_mwe, n_z, n_zwe, n_c, n_cwe, n_dc, n_dcwe;

  assign opnd   = use_lit_i ? lit_i : reg_i;
  assign is_sub = (op_i == OP_SUB) || (op_i == OP_SUBC) || (op_i == OP_CMP);
  assign is_mul = (op_i == OP_MULU) || (op_i == OP_MULS);

  // subtraction: operand + ~W + cin, carry out = no borrow
  always_comb begin
    as_a   = is_sub ? opnd : w_i;
    as_b   = is_sub ? w_i : opnd;
    as_cin = ((op_i == OP_ADDC) || (op_i == OP_SUBC)) ? c_i : is_sub;
  end

  alu8_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i(as_a), .b_i(as_b), .inv_b_i(is_sub), .cin_i(as_cin),
    .sum_o(as_sum), .hc_o(as_hc), .co_o(as_co)
  );

  alu8_mul #(.WIDTH(WIDTH)) u_mul (
    .a_i(w_i), .b_i(opnd),
    .sgn_a_i(op_i == OP_MULS), .sgn_b_i((op_i == OP_MULS) && !use_lit_i),
    .prod_o(prod)
  );

  alu8_unit #(.WIDTH(WIDTH)) u_unit (
    .op_i(op_i), .w_i(w_i), .b_i(opnd), .c_i(c_i),
    .res_o(u_res), .co_o(u_co)
  );

  always_comb begin
    n_res = '0; n_mh = '0;
    n_wr = 1'b0; n_force_w = 1'b0; n_mwe = 1'b0;
    n_c = 1'b0; n_cwe = 1'b0; n_dc = 1'b0; n_dcwe = 1'b0; n_zwe = 1'b0;
    unique case (op_i)
      OP_MOV: begin
        n_wr = 1'b1;
        if (use_lit_i || !dir_i) begin
          n_res = opnd;
          n_zwe = !use_lit_i;
        end else begin
          n_res = w_i;
        end
      end
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
        n_res  = as_sum;
        n_wr   = (op_i != OP_CMP);
        n_c    = as_co;  n_cwe  = 1'b1;
        n_dc   = as_hc;  n_dcwe = 1'b1;
        n_zwe  = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR, OP_NOT, OP_INC, OP_DEC: begin
        n_res = u_res; n_wr = 1'b1; n_zwe = 1'b1;
      end
      OP_RL, OP_RR: begin
        n_res = u_res; n_wr = 1'b1; n_c = u_co; n_cwe = 1'b1;
      end
      OP_SWAP: begin
        n_res = u_res; n_wr = 1'b1;
      end
      OP_MULU, OP_MULS: begin
        n_res = prod[WIDTH-1:0]; n_mh = prod[2*WIDTH-1:WIDTH];
        n_wr = 1'b1; n_mwe = 1'b1; n_force_w = 1'b1;
      end
      default: ;
    endcase
    n_z = (n_res == '0);
  end

  logic to_w;
  assign to_w = n_force_w || use_lit_i || !dir_i || is_mul;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o <= '0; w_we_o <= 1'b0; reg_we_o <= 1'b0;
      mulh_o <= '0; mulh_we_o <= 1'b0;
      z_o <= 1'b0; z_we_o <= 1'b0; c_o <= 1'b0; c_we_o <= 1'b0;
      dc_o <= 1'b0; dc_we_o <= 1'b0;
    end else begin
      res_o     <= n_res;
      w_we_o    <= n_wr && to_w;
      reg_we_o  <= n_wr && !to_w;
      mulh_o    <= n_mh;
      mulh_we_o <= n_mwe;
      z_o       <= n_z;
      z_we_o    <= n_zwe;
      c_o       <= n_c;
      c_we_o    <= n_cwe;
      dc_o      <= n_dc;
      dc_we_o   <= n_dcwe;
    end
  end
endmodule

// File: rtl/alu8_dc_chk.sv
module alu8_dc_chk
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [4:0]       op_i,
  input logic             use_lit_i,
  input logic [WIDTH-1:0] reg_i,
  input logic [WIDTH-1:0] lit_i,
  input logic             w_we_o,
  input logic             reg_we_o,
  input logic             mulh_we_o,
  input logic             z_we_o,
  input logic             c_o,
  input logic             c_we_o,
  input logic             dc_we_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;

  p_one_dest_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(w_we_o && reg_we_o));

  p_lit_to_w_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(use_lit_i) |-> !reg_we_o);

  p_cmp_nowrite_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(op_i == OP_CMP) |-> !w_we_o && !reg_we_o && z_we_o && c_we_o && dc_we_o);

  p_swap_noflag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(op_i == OP_SWAP) |-> !z_we_o && !c_we_o && !dc_we_o);

  p_rl_carry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(op_i == OP_RL) |->
      c_we_o && !z_we_o && (c_o == $past(use_lit_i ? lit_i[WIDTH-1] : reg_i[WIDTH-1])));

  p_mul_mulh_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(op_i == OP_MULU || op_i == OP_MULS) |->
      mulh_we_o && w_we_o && !z_we_o && !c_we_o);

  p_bad_op_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(op_i > OP_MULS) |->
      !w_we_o && !reg_we_o && !mulh_we_o && !z_we_o && !c_we_o && !dc_we_o);
endmodule

bind alu8_dc alu8_dc_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .use_lit_i(use_lit_i),
  .reg_i(reg_i), .lit_i(lit_i), .w_we_o(w_we_o), .reg_we_o(reg_we_o),
  .mulh_we_o(mulh_we_o), .z_we_o(z_we_o), .c_o(c_o), .c_we_o(c_we_o),
  .dc_we_o(dc_we_o)
);

// File: tb/sim_alu8_dc.sv
`timescale 1ns/1ps
module sim_alu8_dc;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [4:0] op_i = '0;
  logic dir_i = 1'b0, use_lit_i = 1'b0, c_i = 1'b0;
  logic [7:0] w_i = 8'h5A, reg_i = 8'hC3, lit_i = 8'h11;
  logic [7:0] res_o, mulh_o;
  logic w_we_o, reg_we_o, mulh_we_o, z_o, z_we_o, c_o, c_we_o, dc_o, dc_we_o;

  always #2.5 clk = ~clk;

  alu8_dc u0 (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op_i), .dir_i(dir_i), .use_lit_i(use_lit_i),
    .w_i(w_i), .reg_i(reg_i), .lit_i(lit_i), .c_i(c_i),
    .res_o(res_o), .w_we_o(w_we_o), .reg_we_o(reg_we_o), .mulh_o(mulh_o),
    .mulh_we_o(mulh_we_o), .z_o(z_o), .z_we_o(z_we_o), .c_o(c_o), .c_we_o(c_we_o),
    .dc_o(dc_o), .dc_we_o(dc_we_o)
  );

  typedef struct {
    logic [7:0] res, mulh;
    logic wwe, rwe, mwe, z, zwe, c, cwe, dc, dcwe;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  function automatic exp_t model(int op, bit dir, bit [7:0] w, bit [7:0] r,
                                 bit [7:0] l, bit ul, bit c, string tag);
    exp_t e;
    int b, s, k, sw, sb, p;
    bit wr, fw;
    e.res = '0; e.mulh = '0; e.wwe = 0; e.rwe = 0; e.mwe = 0;
    e.z = 0; e.zwe = 0; e.c = 0; e.cwe = 0; e.dc = 0; e.dcwe = 0; e.tag = tag;
    b = ul ? int'(l) : int'(r);
    wr = 0; fw = 0;
    case (op)
      0: begin
        wr = 1;
        if (ul || !dir) begin e.res = 8'(b); e.zwe = !ul; end
        else e.res = w;
      end
      1, 2: begin
        k = (op == 2) ? int'(c) : 0;
        s = int'(w) + b + k;
        e.res = 8'(s); e.c = (s > 255); e.dc = ((int'(w) & 15) + (b & 15) + k) > 15;
        wr = 1; e.zwe = 1; e.cwe = 1; e.dcwe = 1;
      end
      3, 4, 5: begin
        k = (op == 4) ? int'(!c) : 0;
        s = b - int'(w) - k;
        e.res = 8'(s); e.c = (s >= 0); e.dc = ((b & 15) - (int'(w) & 15) - k) >= 0;
        wr = (op != 5); e.zwe = 1; e.cwe = 1; e.dcwe = 1;
      end
      6: begin e.res = w & 8'(b); wr = 1; e.zwe = 1; end
      7: begin e.res = w | 8'(b); wr = 1; e.zwe = 1; end
      8: begin e.res = w ^ 8'(b); wr = 1; e.zwe = 1; end
      9: begin e.res = ~8'(b); wr = 1; e.zwe = 1; end
      10: begin e.res = 8'(b + 1); wr = 1; e.zwe = 1; end
      11: begin e.res = 8'(b - 1); wr = 1; e.zwe = 1; end
      12: begin e.res = 8'((b << 1) | int'(c)); e.c = b[7]; wr = 1; e.cwe = 1; end
      13: begin e.res = 8'((b >> 1) | (c ? 128 : 0)); e.c = b[0]; wr = 1; e.cwe = 1; end
      14: begin e.res = 8'(((b & 15) << 4) | (b >> 4)); wr = 1; end
      15, 16: begin
        sw = (op == 16 && w[7]) ? int'(w) - 256 : int'(w);
        sb = (op == 16 && !ul && b >= 128) ? b - 256 : b;
        p = sw * sb;
        e.res = 8'(p); e.mulh = 8'(p >> 8); wr = 1; fw = 1; e.mwe = 1;
      end
      default: ;
    endcase
    e.z = (e.res == 0);
    if (wr) begin
      if (fw || ul || !dir) e.wwe = 1; else e.rwe = 1;
    end
    return e;
  endfunction

  task automatic send(int op, bit dir, bit [7:0] w, bit [7:0] r, bit [7:0] l,
                      bit ul, bit c, string tag);
    @(negedge clk);
    op_i = 5'(op); dir_i = dir; w_i = w; reg_i = r; lit_i = l; use_lit_i = ul; c_i = c;
    q.push_back(model(op, dir, w, r, l, ul, c, tag));
  endtask

  // monitor: outputs of an item appear on the edge after it was driven
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        bit bad;
        e = q.pop_front();
        bad = (w_we_o !== e.wwe) || (reg_we_o !== e.rwe) || (mulh_we_o !== e.mwe) ||
              (z_we_o !== e.zwe) || (c_we_o !== e.cwe) || (dc_we_o !== e.dcwe) ||
              ((e.wwe || e.rwe) && res_o !== e.res) || (e.mwe && mulh_o !== e.mulh) ||
              (e.zwe && z_o !== e.z) || (e.cwe && c_o !== e.c) || (e.dcwe && dc_o !== e.dc);
        checks++;
        if (bad) begin
          fails++;
          $display("FAIL %s: got res=%h we=%b%b mh=%h/%b z=%b/%b c=%b/%b dc=%b/%b exp res=%h we=%b%b mh=%h/%b z=%b/%b c=%b/%b dc=%b/%b",
                   e.tag, res_o, w_we_o, reg_we_o, mulh_o, mulh_we_o, z_o, z_we_o, c_o, c_we_o,
                   dc_o, dc_we_o, e.res, e.wwe, e.rwe, e.mulh, e.mwe, e.z, e.zwe, e.c, e.cwe,
                   e.dc, e.dcwe);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(100000 * 5);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    op_i = 5'd1; use_lit_i = 1'b0;
    repeat (3) @(negedge clk);
    // R12: reset clears every output
    checks++;
    if ({res_o, mulh_o, w_we_o, reg_we_o, mulh_we_o, z_o, z_we_o, c_o, c_we_o, dc_o, dc_we_o} !== '0) begin
      fails++;
      $display("FAIL R12: outputs under reset %h/%h, expected all zero", res_o, mulh_o);
    end
    rst_ni = 1'b1;

    // R1 add / add-with-carry
    send(1, 0, 8'h0F, 8'h01, 8'h00, 0, 0, "R1 nibble carry");
    send(1, 0, 8'hFF, 8'h01, 8'h00, 0, 0, "R1 wrap zero");
    send(2, 0, 8'h7F, 8'h00, 8'h80, 1, 1, "R1 addc literal");
    send(2, 1, 8'h10, 8'h20, 8'h00, 0, 0, "R1 addc to reg");
    // R2 subtract / subtract-with-borrow
    send(3, 0, 8'h01, 8'h10, 8'h00, 0, 0, "R2 nibble borrow");
    send(3, 1, 8'h02, 8'h01, 8'h00, 0, 0, "R2 borrow");
    send(4, 0, 8'h05, 8'h05, 8'h00, 0, 0, "R2 subc c0");
    send(4, 0, 8'h05, 8'h00, 8'h05, 1, 1, "R2 subc c1 zero");
    // R3 compare
    send(5, 1, 8'h33, 8'h33, 8'h00, 0, 0, "R3 equal");
    send(5, 0, 8'h40, 8'h00, 8'h3F, 1, 0, "R3 less");
    // R4 logic and step
    send(6, 0, 8'hF0, 8'h0F, 8'h00, 0, 1, "R4 and zero");
    send(7, 1, 8'hF0, 8'h0F, 8'h00, 0, 1, "R4 or");
    send(8, 0, 8'hAA, 8'h00, 8'hAA, 1, 0, "R4 xor lit");
    send(9, 1, 8'h00, 8'hFF, 8'h00, 0, 0, "R4 not");
    send(10, 0, 8'h00, 8'hFF, 8'h00, 0, 1, "R4 inc wrap");
    send(11, 1, 8'h00, 8'h00, 8'h00, 0, 1, "R4 dec wrap");
    // R5 rotates
    send(12, 1, 8'h00, 8'h80, 8'h00, 0, 1, "R5 rl");
    send(13, 0, 8'h00, 8'h01, 8'h00, 0, 0, "R5 rr");
    send(13, 1, 8'h00, 8'h00, 8'h00, 0, 1, "R5 rr carry in");
    // R6 swap
    send(14, 1, 8'h00, 8'hA5, 8'h00, 0, 1, "R6 swap");
    // R7 / R8 multiply
    send(15, 1, 8'hFF, 8'hFF, 8'h00, 0, 0, "R7 mulu max");
    send(16, 0, 8'hFF, 8'h02, 8'h00, 0, 0, "R8 muls reg");
    send(16, 1, 8'hFF, 8'h00, 8'h80, 1, 0, "R8 muls lit zext");
    send(16, 0, 8'hFF, 8'h80, 8'h00, 0, 0, "R8 muls reg sext");
    // R9 routing
    send(1, 1, 8'h01, 8'h00, 8'h02, 1, 0, "R9 literal forces W");
    // R10 moves
    send(0, 0, 8'h12, 8'h00, 8'h00, 0, 0, "R10 mov reg to W");
    send(0, 1, 8'h77, 8'h00, 8'h00, 0, 0, "R10 mov W to reg");
    send(0, 1, 8'h77, 8'h00, 8'h00, 1, 0, "R10 mov literal");
    // R11 unused codes
    send(17, 0, 8'h01, 8'h01, 8'h00, 0, 1, "R11 op17");
    send(31, 1, 8'h01, 8'h01, 8'h00, 0, 1, "R11 op31");
    // mixed patterns
    for (int i = 0; i < 300; i++)
      send(int'($urandom_range(0, 31)), 1'($urandom), 8'($urandom), 8'($urandom),
           8'($urandom), 1'($urandom), 1'($urandom), "R1 R2 R4 R8 mixed");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule